// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block follows each instruction through a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It keeps an eight-bit fault status vector for every instruction. Each stage can set fault bits for the instruction it holds. A non-empty vector blocks that instruction's register and memory writes at once. No stage traps where it detects a fault. A fault is only acted on when its instruction reaches write-back. Instructions reach write-back in program order, so an older instruction's fault is always taken before a younger one's, whichever stage detected each.

The datapath drives the fault strobes, a global advance, and the PC and valid of each instruction entering fetch. It receives a write-permit bit per stage. When an exception is taken, the block reports the cause code and faulting PC in the same cycle. It also raises a flush that empties every stage and drops any instruction entering fetch in that cycle.

Top module: `precise_fault_tracker`

## Requirements
- R1: Fault input bits map to stages as follows. Bits 0, 1 and 2 are fetch page fault, fetch misalignment and fetch protection. Bit 3 is decode illegal opcode. Bit 4 is execute arithmetic fault. Bits 5, 6 and 7 are memory-stage page fault, misalignment and protection. A bit is recorded only by the stage it names; all other stages ignore it, and write-back records none.
- R2: A recorded fault bit stays with its instruction through stalls and stage moves until that instruction leaves the pipeline.
- R3: `wr_ok_o[s]` is 1 exactly when stage s (0 = fetch, 4 = write-back) holds a valid instruction, that instruction's status is zero including strobes of the current cycle, and no exception is taken in that cycle.
- R4: `exc_o` is 1 in every cycle where write-back holds a valid instruction with a non-zero status, regardless of `adv_i`.
- R5: `exc_cause_o` is the index of the lowest set status bit, so the fault from the earliest stage wins.
- R6: `exc_pc_o` is the PC that entered with the faulting instruction.
- R7: In the cycle after `exc_o`, no stage holds an instruction, including one offered on `new_vld_i` in the exception cycle. `flush_o` is high with `exc_o`.
- R8: When an older instruction has a memory-stage fault and a younger one has an earlier fetch fault, the older one's exception is reported and the younger one never raises one.
- R9: Bubbles carry an all-zero status and never cause an exception, even with fault strobes active.
- R10: After reset the pipeline is empty: all `wr_ok_o` bits and `exc_o` are 0.
- R11: With `adv_i` low and no exception, every stage keeps its instruction. With `adv_i` high, every instruction moves one stage on and write-back retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Pipeline advance this cycle |
| new_vld_i | input | 1 | An instruction enters fetch on advance |
| new_pc_i | input | PC_W | PC of the entering instruction |
| fault_i | input | 8 | Fault strobes, bit meaning per R1 |
| wr_ok_o | output | 5 | Per-stage write permit, bit 0 = fetch |
| exc_o | output | 1 | Exception taken this cycle |
| exc_cause_o | output | 3 | Cause code (status bit index) |
| exc_pc_o | output | PC_W | PC of the faulting instruction |
| flush_o | output | 1 | Invalidate all younger stages, redirect fetch |

## Verification
The bench builds the block with PC_W = 8. This lets the PC of each test instruction carry its own fault mask. It sends one instruction through the pipeline for every one of the 256 possible status vectors, with that whole mask on the strobes in every cycle. This covers every cause priority, every case of stage ownership, and every write-permit pattern. Directed runs then cover the ordering of two faulting instructions, sticky faults during a stall, and an exception taken while the pipeline is held.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int NSTG    = 5;
  localparam int FLT_W   = 8;
  localparam int CAUSE_W = $clog2(FLT_W);

  // fault bits owned by each stage; bit order is also the cause priority
  function automatic logic [FLT_W-1:0] stage_mask(input int s);
    case (s)
      0:       stage_mask = 8'b0000_0111;
      1:       stage_mask = 8'b0000_1000;
      2:       stage_mask = 8'b0001_0000;
      3:       stage_mask = 8'b1110_0000;
      default: stage_mask = 8'b0000_0000;
    endcase
  endfunction
endpackage

// File: rtl/pft_stage.sv
module pft_stage
  import pft_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             kill_i,
  input  logic             in_vld_i,
  input  logic [PC_W-1:0]  in_pc_i,
  input  logic [FLT_W-1:0] in_st_i,
  input  logic [FLT_W-1:0] own_flt_i,
  output logic             vld_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [FLT_W-1:0] cur_st_o
);
  logic             vld_q, vld_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             pc_en;
  logic [FLT_W-1:0] st_q, st_d;

  assign cur_st_o = vld_q ? (st_q | own_flt_i) : '0;
  assign vld_o    = vld_q;
  assign pc_o     = pc_q;
  assign pc_en    = load_i & ~kill_i;

  always_comb begin
    vld_d = vld_q;
    st_d  = cur_st_o;
    pc_d  = in_pc_i;
    if (kill_i) begin
      vld_d = 1'b0;
      st_d  = '0;
    end else if (load_i) begin
      vld_d = in_vld_i;
      st_d  = in_st_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      st_q  <= '0;
      pc_q  <= '0;
    end else begin
      vld_q <= vld_d;
      st_q  <= st_d;
      if (pc_en) pc_q <= pc_d;
    end
  end

  // R2
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !load_i && !kill_i) |=> ((cur_st_o & $past(cur_st_o)) == $past(cur_st_o)));

  // R11
  hold_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !load_i && !kill_i) |=> (vld_o && $stable(pc_o)));
endmodule

// File: rtl/pft_cause_enc.sv
module pft_cause_enc
  import pft_pkg::*;
(
  input  logic [FLT_W-1:0]   st_i,
  output logic [CAUSE_W-1:0] cause_o
);
  always_comb begin
    cause_o = '0;
    for (int i = FLT_W - 1; i >= 0; i--) begin
      if (st_i[i]) cause_o = CAUSE_W'(i);
    end
  end
endmodule

// File: rtl/precise_fault_tracker.sv
module precise_fault_tracker
  import pft_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_i,
  input  logic               new_vld_i,
  input  logic [PC_W-1:0]    new_pc_i,
  input  logic [FLT_W-1:0]   fault_i,
  output logic [NSTG-1:0]    wr_ok_o,
  output logic               exc_o,
  output logic [CAUSE_W-1:0] exc_cause_o,
  output logic [PC_W-1:0]    exc_pc_o,
  output logic               flush_o
);
  localparam int WB = NSTG - 1;

  logic             vld [NSTG];
  logic [PC_W-1:0]  pc  [NSTG];
  logic [FLT_W-1:0] cur [NSTG];
  logic             exc;
  logic             vld_any;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    logic             up_vld;
    logic [PC_W-1:0]  up_pc;
    logic [FLT_W-1:0] up_st;
    if (s == 0) begin : g_head
      assign up_vld = new_vld_i;
      assign up_pc  = new_pc_i;
      assign up_st  = '0;
    end else begin : g_body
      assign up_vld = vld[s-1];
      assign up_pc  = pc[s-1];
      assign up_st  = cur[s-1];
    end

    pft_stage #(.PC_W(PC_W)) i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (adv_i),
      .kill_i   (exc),
      .in_vld_i (up_vld),
      .in_pc_i  (up_pc),
      .in_st_i  (up_st),
      .own_flt_i(fault_i & stage_mask(s)),
      .vld_o    (vld[s]),
      .pc_o     (pc[s]),
      .cur_st_o (cur[s])
    );

    assign wr_ok_o[s] = vld[s] & ~(|cur[s]) & ~exc;
  end

  assign exc = vld[WB] & (|cur[WB]);

  pft_cause_enc i_cause (
    .st_i   (cur[WB]),
    .cause_o(exc_cause_o)
  );

  assign exc_o    = exc;
  assign flush_o  = exc;
  assign exc_pc_o = pc[WB];

  always_comb begin
    vld_any = 1'b0;
    for (int s = 0; s < NSTG; s++) vld_any = vld_any | vld[s];
  end

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |=> !vld_any);

  // R5
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> cur[WB][exc_cause_o]);

  // R5
  cause_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> ((cur[WB] & ((FLT_W'(1) << exc_cause_o) - FLT_W'(1))) == '0));

  // R11
  retire_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !exc && vld[WB-1]) |=> (vld[WB] && pc[WB] == $past(pc[WB-1])));
endmodule

// File: tb/test_precise_fault_tracker.sv
module test_precise_fault_tracker;
  localparam int PC_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            adv;
  logic            nv;
  logic [PC_W-1:0] npc;
  logic [7:0]      flt;
  logic [4:0]      wr_ok;
  logic            exc;
  logic [2:0]      cause;
  logic [PC_W-1:0] epc;
  logic            flush;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  precise_fault_tracker #(.PC_W(PC_W)) i_precise_fault_tracker (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .new_vld_i(nv), .new_pc_i(npc),
    .fault_i(flt), .wr_ok_o(wr_ok), .exc_o(exc), .exc_cause_o(cause),
    .exc_pc_o(epc), .flush_o(flush));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic a, input logic v, input logic [7:0] p, input logic [7:0] f);
    adv = a; nv = v; npc = p; flt = f;
    #1;
  endtask

  function automatic int bit_stage(input int b);
    if (b < 3) return 0;
    if (b == 3) return 1;
    if (b == 4) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] upto(input int s);
    logic [7:0] r = '0;
    for (int b = 0; b < 8; b++) if (bit_stage(b) <= s) r[b] = 1'b1;
    return r;
  endfunction

  function automatic int low_bit(input logic [7:0] m);
    int r = 0;
    for (int i = 7; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    adv = 1'b0; nv = 1'b0; npc = '0; flt = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 wr_ok in reset", 32'(wr_ok), 0);
    chk("R10 exc in reset", 32'(exc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1, 0, 0, 8'hFF);
    chk("R9 empty pipe with strobes", 32'(exc), 0);
    chk("R10 wr_ok after reset", 32'(wr_ok), 0);
    cyc();

    // sweep every status vector; the mask stays on the strobes all the way
    for (int m = 0; m < 256; m++) begin
      drive(1, 1, 8'(m), 8'h00);
      cyc();
      for (int s = 0; s < 5; s++) begin
        logic okb;
        drive(1, 0, 0, 8'(m));
        okb = ((8'(m) & upto(s)) == 8'h00);
        chk("R1 R3 wr_ok per stage", 32'(wr_ok), 32'(okb) << s);
        if (s < 4) begin
          chk("R9 R4 no early exception", 32'(exc), 0);
        end else begin
          chk("R4 exception at write-back", 32'(exc), 32'(m != 0));
          chk("R7 flush with exception", 32'(flush), 32'(m != 0));
          if (m != 0) begin
            chk("R5 cause", 32'(cause), 32'(low_bit(8'(m))));
            chk("R6 faulting pc", 32'(epc), 32'(m));
          end
        end
        cyc();
      end
      drive(1, 0, 0, 8'h00);
      chk("R7 pipe empty after", 32'(wr_ok), 0);
      chk("R7 no repeat exception", 32'(exc), 0);
    end

    // ordering: older MEM fault against younger fetch fault
    drive(1, 1, 8'h10, 8'h00); cyc();
    drive(1, 1, 8'h11, 8'h00); cyc();
    drive(1, 0, 0, 8'h01);
    chk("R3 A ok, B blocked", 32'(wr_ok), 32'b00010);
    cyc();
    drive(1, 0, 0, 8'h00);
    chk("R2 B stays blocked", 32'(wr_ok), 32'b00100);
    cyc();
    drive(1, 0, 0, 8'h20);
    chk("R3 both blocked", 32'(wr_ok), 0);
    cyc();
    drive(1, 1, 8'h20, 8'h00);
    chk("R8 older exception first", 32'(exc), 1);
    chk("R8 cause of older", 32'(cause), 5);
    chk("R8 pc of older", 32'(epc), 32'h10);
    chk("R3 no writes in exception cycle", 32'(wr_ok), 0);
    cyc();
    for (int k = 0; k < 5; k++) begin
      drive(1, 0, 0, 8'h00);
      chk("R7 younger and entering flushed", 32'(wr_ok), 0);
      chk("R8 younger never traps", 32'(exc), 0);
      cyc();
    end

    // stall in decode: strobe seen once, kept
    drive(1, 1, 8'h33, 8'h00); cyc();
    drive(1, 0, 0, 8'h00); cyc();
    drive(0, 0, 0, 8'h00);
    chk("R11 held in decode", 32'(wr_ok), 32'b00010);
    cyc();
    drive(0, 0, 0, 8'h08);
    chk("R3 decode blocked", 32'(wr_ok), 0);
    cyc();
    drive(1, 0, 0, 8'h00);
    chk("R2 sticky after stall", 32'(wr_ok), 0);
    cyc();
    drive(1, 0, 0, 8'h00); cyc();
    drive(1, 0, 0, 8'h00); cyc();
    drive(1, 0, 0, 8'h00);
    chk("R2 exception from stalled fault", 32'(exc), 1);
    chk("R5 cause decode", 32'(cause), 3);
    chk("R6 pc 33", 32'(epc), 32'h33);
    cyc();

    // exception while held at write-back
    drive(1, 1, 8'h44, 8'h00); cyc();
    drive(1, 0, 0, 8'h00); cyc();
    drive(1, 0, 0, 8'h00); cyc();
    drive(1, 0, 0, 8'h10); cyc();
    drive(1, 0, 0, 8'h00); cyc();
    drive(0, 0, 0, 8'h00);
    chk("R4 exception without advance", 32'(exc), 1);
    chk("R5 cause execute", 32'(cause), 4);
    cyc();
    drive(0, 0, 0, 8'h00);
    chk("R7 cleared without advance", 32'(exc), 0);
    chk("R7 empty without advance", 32'(wr_ok), 0);

    finish_run();
  end
endmodule